// File: doc/BRIEF.md
# Programmable Reference Divider

This block divides the selected reference clock down before it reaches the reference side of the phase-frequency comparator. The reference arrives already sampled into the system clock domain as a one-cycle strobe, one for each reference edge. The block counts these strobes and emits a one-cycle enable pulse toward the comparator once every R strobes. R is a 14-bit value loaded through two byte-wide configuration writes.

The written value is held in a staging register. It moves into the active divider only at a terminal count or at a counter reset, so a count is never cut short or stretched by a write. Two reset sources clear the count and realign the output phase. One is a reset bit that the feedback counters also use. The other is a synchronisation request.

Top module: `ref_divider`

## Requirements
- R1: A write with `cfgWrLo` stores `cfgData[7:0]` as divide bits 7:0. A write with `cfgWrHi` stores `cfgData[5:0]` as divide bits 13:8, and `cfgData[7:6]` are ignored. The full range 0 to 16383 is usable.
- R2: With an active divide value of 0 or 1, every accepted strobe produces a `pfdEn` pulse in the following cycle.
- R3: With an active divide value R ≥ 2, exactly one `pfdEn` pulse appears for every R accepted strobes. The pulse is one cycle wide and comes in the cycle after the R-th strobe.
- R4: A new staged value becomes active only at the next terminal count or at a `syncReq`/`cntrRst` cycle. A count in progress finishes with the old value.
- R5: A cycle with `syncReq` high clears the count, holds `pfdEn` low in the next cycle and ignores a strobe in the same cycle. The first pulse after it follows the R-th later strobe.
- R6: A cycle with `cntrRst` high behaves exactly as `syncReq` does in R5.
- R7: After system reset (`rstN` low), the count, both configuration registers and the active value are zero and `pfdEn` is low, so the block divides by 1.
- R8: `pfdEn` is never high except in the cycle right after an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous system reset |
| refStrobe | input | 1 | One-cycle strobe per selected reference edge |
| cfgWrLo | input | 1 | Write strobe for divide bits 7:0 |
| cfgWrHi | input | 1 | Write strobe for divide bits 13:8 |
| cfgData | input | 8 | Configuration write data |
| cntrRst | input | 1 | Counter reset shared with the feedback counters |
| syncReq | input | 1 | Synchronisation request; realigns the divider |
| pfdEn | output | 1 | One-cycle enable pulse to the comparator reference input |

## Verification
The bench targets the pass-through pair 0 and 1. A design that treats 0 as a huge divide would go silent, and one that treats 1 as divide-by-2 would drop every other pulse. It writes a new value in the middle of a count. A design that loads the value at once would pulse early or late in that period. It also raises a reset in the same cycle as a strobe, and a design that counts that strobe would pulse one strobe too soon. Finally, it runs the full 16383 count with the two spare high data bits set. A wrong high-byte mask or too narrow a counter would change the period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int DIV_W = 14;

  typedef struct packed {
    logic             clr;      // clear count, drop any pulse
    logic [DIV_W-1:0] lastIdx;  // count index at which the period ends
  } refdiv_ctl_t;
endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrLo,
  input  logic              cfgWrHi,
  input  logic [BYTE_W-1:0] cfgData,
  input  logic              cntrRst,
  input  logic              syncReq,
  input  logic              termHit,
  output refdiv_ctl_t       ctl,
  output logic [DIV_W-1:0]  activeR
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [BYTE_W-1:0] stageLo;
  logic [HI_W-1:0]   stageHi;
  logic              clrNow;
  logic              loadNow;

  assign clrNow  = syncReq | cntrRst;
  assign loadNow = clrNow | termHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageLo <= '0;
      stageHi <= '0;
    end else begin
      if (cfgWrLo) stageLo <= cfgData;
      if (cfgWrHi) stageHi <= cfgData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        activeR <= '0;
    else if (loadNow) activeR <= {stageHi, stageLo};
  end

  always_comb begin
    ctl.clr = clrNow;
    if (activeR < DIV_W'(2)) ctl.lastIdx = '0;
    else                     ctl.lastIdx = activeR - DIV_W'(1);
  end
endmodule

// File: rtl/refdiv_datapath.sv
module refdiv_datapath
  import refdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refStrobe,
  input  refdiv_ctl_t      ctl,
  output logic             termHit,
  output logic [DIV_W-1:0] cnt,
  output logic             pfdEn
);
  assign termHit = refStrobe & ~ctl.clr & (cnt == ctl.lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      pfdEn <= 1'b0;
    end else if (ctl.clr) begin
      cnt   <= '0;
      pfdEn <= 1'b0;
    end else if (refStrobe) begin
      cnt   <= termHit ? '0 : cnt + DIV_W'(1);
      pfdEn <= termHit;
    end else begin
      pfdEn <= 1'b0;
    end
  end
endmodule

// File: rtl/ref_divider.sv
module ref_divider
  import refdiv_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refStrobe,
  input  logic              cfgWrLo,
  input  logic              cfgWrHi,
  input  logic [BYTE_W-1:0] cfgData,
  input  logic              cntrRst,
  input  logic              syncReq,
  output logic              pfdEn
);
  refdiv_ctl_t      ctl;
  logic             termHit;
  logic [DIV_W-1:0] activeR;
  logic [DIV_W-1:0] cnt;

  refdiv_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrLo(cfgWrLo), .cfgWrHi(cfgWrHi),
    .cfgData(cfgData), .cntrRst(cntrRst), .syncReq(syncReq),
    .termHit(termHit), .ctl(ctl), .activeR(activeR)
  );

  refdiv_datapath u_dp (
    .clk(clk), .rstN(rstN), .refStrobe(refStrobe), .ctl(ctl),
    .termHit(termHit), .cnt(cnt), .pfdEn(pfdEn)
  );
endmodule

// File: rtl/ref_divider_chk.sv
module ref_divider_chk
  import refdiv_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             refStrobe,
  input logic             cntrRst,
  input logic             syncReq,
  input logic             pfdEn,
  input logic [DIV_W-1:0] activeR,
  input logic [DIV_W-1:0] lastIdx,
  input logic [DIV_W-1:0] cnt
);
  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    pfdEn |-> $past(refStrobe) && !$past(syncReq) && !$past(cntrRst)); // R8
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |=> !pfdEn && (cnt == '0)); // R5
  AST_CRST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cntrRst |=> !pfdEn && (cnt == '0)); // R6
  AST_BYPASS_EVERY: assert property (@(posedge clk) disable iff (!rstN)
    (refStrobe && !syncReq && !cntrRst && (activeR < DIV_W'(2))) |=> pfdEn); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastIdx); // R3
  AST_LOAD_POINT: assert property (@(posedge clk) disable iff (!rstN)
    (activeR != $past(activeR)) |-> (pfdEn || $past(syncReq) || $past(cntrRst))); // R4
endmodule

bind ref_divider ref_divider_chk u_chk (
  .clk(clk), .rstN(rstN), .refStrobe(refStrobe), .cntrRst(cntrRst),
  .syncReq(syncReq), .pfdEn(pfdEn), .activeR(activeR),
  .lastIdx(ctl.lastIdx), .cnt(cnt)
);

// File: tb/ref_divider_bench.sv
module ref_divider_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refStrobe = 1'b0, cfgWrLo = 1'b0, cfgWrHi = 1'b0;
  logic cntrRst = 1'b0, syncReq = 1'b0;
  logic [7:0] cfgData = '0;
  logic pfdEn;

  int checks = 0;
  int errors = 0;
  int pulses;

  // reference model state
  logic [7:0]  mLo = '0;
  logic [5:0]  mHi = '0;
  logic [13:0] mAct = '0;
  logic [13:0] mCnt = '0;
  logic        mOut = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_divider u_ref_divider (
    .clk(clk), .rstN(rstN), .refStrobe(refStrobe), .cfgWrLo(cfgWrLo),
    .cfgWrHi(cfgWrHi), .cfgData(cfgData), .cntrRst(cntrRst),
    .syncReq(syncReq), .pfdEn(pfdEn)
  );

  function automatic logic [13:0] lastOf(input logic [13:0] r);
    return (r < 14'd2) ? 14'd0 : r - 14'd1;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pfdEn actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, model the edge, compare at next negedge
  task automatic step(input logic s, input logic wl, input logic wh,
                      input logic [7:0] d, input logic sy, input logic cr,
                      input string tag);
    logic clr, term;
    refStrobe = s; cfgWrLo = wl; cfgWrHi = wh; cfgData = d;
    syncReq = sy; cntrRst = cr;
    @(posedge clk);
    clr  = sy | cr;
    term = s && !clr && (mCnt == lastOf(mAct));
    if (clr || term) mAct = {mHi, mLo};
    if (clr) begin mCnt = '0; mOut = 1'b0; end
    else if (s) begin mCnt = term ? 14'd0 : mCnt + 14'd1; mOut = term; end
    else mOut = 1'b0;
    if (wl) mLo = d;
    if (wh) mHi = d[5:0];
    @(negedge clk);
    if (pfdEn) pulses++;
    check(tag, pfdEn, mOut);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic strobe(input string tag);
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic writeR(input logic [13:0] r, input string tag);
    step(1'b0, 1'b1, 1'b0, r[7:0], 1'b0, 1'b0, tag);
    step(1'b0, 1'b0, 1'b1, {2'b11, r[13:8]}, 1'b0, 1'b0, tag);
  endtask

  task automatic sync(input string tag);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R7 reset output", pfdEn, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R7: after reset, divide by 1
    pulses = 0;
    repeat (4) strobe("R7 div1 after reset");
    checkInt("R7 pulses after reset", pulses, 4);

    // R2: value 0 and value 1 both pass through
    writeR(14'd1, "R2 write1"); sync("R2 load1");
    pulses = 0; repeat (5) strobe("R2 div1"); checkInt("R2 value 1 pulses", pulses, 5);
    writeR(14'd0, "R2 write0"); sync("R2 load0");
    pulses = 0; repeat (5) strobe("R2 div0"); checkInt("R2 value 0 pulses", pulses, 5);

    // R4: mid-count change waits for terminal count
    writeR(14'd5, "R4 write5"); sync("R4 load5");
    strobe("R4 old"); strobe("R4 old");
    writeR(14'd3, "R4 write3");
    pulses = 0;
    repeat (2) strobe("R4 finish old");
    checkInt("R4 no early pulse", pulses, 0);
    strobe("R4 fifth");
    checkInt("R4 old period kept", pulses, 1);
    pulses = 0; repeat (6) strobe("R4 new period");
    checkInt("R4 new value active", pulses, 2);

    // R5 / R6: realignment; strobe coincident with reset is ignored
    writeR(14'd4, "R5 write4"); sync("R5 load4");
    strobe("R5 pre"); strobe("R5 pre");
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R5 sync with strobe");
    pulses = 0; repeat (3) strobe("R5 after sync");
    checkInt("R5 no pulse before 4th", pulses, 0);
    strobe("R5 fourth"); checkInt("R5 pulse on 4th", pulses, 1);
    strobe("R6 pre"); strobe("R6 pre"); strobe("R6 pre");
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6 counter reset");
    pulses = 0; repeat (3) strobe("R6 after reset");
    checkInt("R6 no pulse before 4th", pulses, 0);
    strobe("R6 fourth"); checkInt("R6 pulse on 4th", pulses, 1);

    // R1 / R3: full 14-bit range, spare high bits set by writeR
    writeR(14'd16383, "R1 write max"); sync("R1 load max");
    pulses = 0; repeat (16382) strobe("R3 long count");
    checkInt("R1 no pulse before 16383", pulses, 0);
    strobe("R1 last"); checkInt("R1 pulse at 16383", pulses, 1);

    // R3: counts under random stimulus with occasional writes and resets
    writeR(14'd7, "R3 write7"); sync("R3 load7");
    pulses = 0; repeat (21) begin strobe("R3 div7"); idle("R3 gap"); end
    checkInt("R3 one per seven", pulses, 3);
    for (int i = 0; i < 4000; i++) begin
      logic s, wl, wh, sy, cr;
      logic [7:0] d;
      s  = ($urandom % 3) != 0;
      wl = ($urandom % 40) == 0;
      wh = ($urandom % 80) == 0;
      d  = wh ? 8'($urandom % 2) : 8'($urandom % 12);
      sy = ($urandom % 150) == 0;
      cr = ($urandom % 200) == 0;
      step(s, wl, wh, d, sy, cr, "R3 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule